// File: doc/BRIEF.md
# Slotted Loop-Buffer Contention Scheduler

This block is the electronic decision logic of an N-port slotted packet switch whose contention store is one shared recirculating loop with B channels, each channel holding at most one packet. Packets have one fixed length and arrive aligned to slot boundaries, and every clock cycle is one slot. In each slot the block reads, for every input, a valid flag and a destination port. It then decides, for every output, whether that output takes a packet out of the loop, takes one straight from an input, or stays idle. Every arriving packet is given exactly one fate: sent directly, written into a free loop channel, or dropped.

The decision outputs are combinational in the slot's inputs and the loop state. The loop state is a channel occupancy mask, plus a destination and an age for each channel, and it is registered at the end of the slot. A parameter picks one of two loop variants. With `BYPASS = 1` an input may go straight to an idle output, and a channel read in a slot can take a new packet in that same slot. With `BYPASS = 0` every packet passes through the loop, and a channel that was read stays unusable for one further slot.

Top module: `loop_buffer_sched`

## Requirements
- R1: After reset the loop holds no packets: every `occ_cnt` field is 0, no output is fed from the loop and `ch_rd` is 0.
- R2: In each slot, every output with at least one packet in the loop is fed from the loop. `out_src` field j (bits 2j+1:2j) reads 2'b01, and exactly one channel is read for it: the oldest, with ties going to the lowest channel index. That channel index appears in `out_ch` field j, and its `ch_rd` bit is set.
- R3: With `BYPASS = 1`, an output that has nothing in the loop and is targeted by one or more valid inputs takes the lowest-numbered such input directly. `out_src` field j reads 2'b10, the input index is in `out_in` field j, and `in_dir` is set for that input. The other inputs for that output go to the loop.
- R4: With `BYPASS = 0`, no input is ever sent directly, and every valid input is written to the loop or dropped.
- R5: A packet going to the loop is written only into a channel that no resident packet will still hold after the slot. Inputs are served in ascending index order, each taking the lowest-indexed usable channel, which is given in `in_ch` field i.
- R6: A valid input that finds no usable channel is dropped (`in_drop` set), and `drop_cnt` equals the number of inputs dropped in the slot.
- R7: With `BYPASS = 1`, a channel read in a slot can accept a new packet in that same slot.
- R8: With `BYPASS = 0`, a channel read in slot t cannot be written in slot t or t+1, and is usable again from slot t+2.
- R9: `occ_cnt` field j (CNT_W bits) gives, at the start of the slot, the number of loop packets held for output j. Their sum never exceeds the channel count.
- R10: Inputs whose output already has a packet in the loop are never sent directly, even with `BYPASS = 1`.
- R11: An input whose valid flag is low gets no command (`in_wr`, `in_dir`, `in_drop` all 0), whatever its destination field holds. Unused `in_ch`, `out_ch` and `out_in` fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | N_PORTS | Packet present on input i |
| in_dst | input | N_PORTS*DST_W | Destination port of input i, field i |
| in_wr | output | N_PORTS | Input i is written into the loop |
| in_ch | output | N_PORTS*CH_W | Loop channel assigned to input i |
| in_dir | output | N_PORTS | Input i goes straight to its output |
| in_drop | output | N_PORTS | Input i is discarded |
| out_src | output | 2*N_PORTS | Output feed: 00 idle, 01 loop, 10 direct |
| out_ch | output | N_PORTS*CH_W | Channel read for output j |
| out_in | output | N_PORTS*DST_W | Input sent directly to output j |
| ch_rd | output | N_CH | Channel read out this slot, else held |
| drop_cnt | output | DRP_W | Number of drops this slot |
| occ_cnt | output | N_PORTS*CNT_W | Loop packets held per output |

## Verification
The checker takes for granted that the destination field of every valid input names an existing port. Every destination the bench drives is therefore drawn from 0 to N_PORTS-1. The oldest-first rule rests on ages that never saturate. The stimulus keeps residence short: each output drains one packet per slot and at most eight channels exist, and bursts are broken by idle slots, so every packet leaves far sooner than the age limit. Both loop variants receive the same input sequence, so the bypass and recovery behaviours can be compared slot by slot.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    // Feed selection for one output, as presented on out_src
    typedef enum logic [1:0] {
        SRC_IDLE = 2'b00,
        SRC_LOOP = 2'b01,
        SRC_DIR  = 2'b10
    } src_e;
endpackage

// File: rtl/lbs_oldest_pick.sv
// Per output: pick the oldest resident packet, lowest channel on equal age
module lbs_oldest_pick #(
    parameter int N_OUT = 4,
    parameter int N_CH  = 8,
    parameter int DST_W = 2,
    parameter int AGE_W = 6
) (
    input  logic [N_CH-1:0]                  occ,
    input  logic [N_CH*DST_W-1:0]            dst,
    input  logic [N_CH*AGE_W-1:0]            age,
    output logic [N_OUT-1:0]                 hit,
    output logic [N_OUT*$clog2(N_CH)-1:0]    sel,
    output logic [N_CH-1:0]                  rd
);
    localparam int CH_W = $clog2(N_CH);

    always_comb begin
        hit = '0;
        sel = '0;
        rd  = '0;
        for (int j = 0; j < N_OUT; j++) begin
            logic             found;
            logic [AGE_W-1:0] best_age;
            logic [CH_W-1:0]  best;
            found    = 1'b0;
            best_age = '0;
            best     = '0;
            for (int c = 0; c < N_CH; c++) begin
                if (occ[c] && dst[c*DST_W +: DST_W] == DST_W'(j) &&
                    (!found || age[c*AGE_W +: AGE_W] > best_age)) begin
                    found    = 1'b1;
                    best_age = age[c*AGE_W +: AGE_W];
                    best     = CH_W'(c);
                end
            end
            hit[j]                = found;
            sel[j*CH_W +: CH_W]   = found ? best : '0;
            if (found) rd[best]   = 1'b1;
        end
    end
endmodule

// File: rtl/lbs_admit.sv
// Resolve every arriving packet: direct, write to a free channel, or drop
module lbs_admit #(
    parameter int N_IO   = 4,
    parameter int N_CH   = 8,
    parameter int DST_W  = 2,
    parameter bit BYPASS = 1'b1
) (
    input  logic [N_IO-1:0]               in_vld,
    input  logic [N_IO*DST_W-1:0]         in_dst,
    input  logic [N_CH-1:0]               free,
    input  logic [N_IO-1:0]               out_busy,
    output logic [N_IO-1:0]               wr,
    output logic [N_IO*$clog2(N_CH)-1:0]  ch,
    output logic [N_IO-1:0]               dir,
    output logic [N_IO-1:0]               drop,
    output logic [N_IO-1:0]               dir_taken,
    output logic [N_IO*DST_W-1:0]         dir_src
);
    localparam int CH_W = $clog2(N_CH);

    always_comb begin
        logic [N_CH-1:0]  avail;
        logic [N_IO-1:0]  taken;
        logic [DST_W-1:0] d;
        logic             got;
        avail   = free;
        taken   = '0;
        wr      = '0;
        ch      = '0;
        dir     = '0;
        drop    = '0;
        dir_src = '0;
        d       = '0;
        got     = 1'b0;
        for (int i = 0; i < N_IO; i++) begin
            if (in_vld[i]) begin
                d = in_dst[i*DST_W +: DST_W];
                if (BYPASS && !out_busy[d] && !taken[d]) begin
                    dir[i]                     = 1'b1;
                    taken[d]                   = 1'b1;
                    dir_src[d*DST_W +: DST_W]  = DST_W'(i);
                end else begin
                    got = 1'b0;
                    for (int c = 0; c < N_CH; c++) begin
                        if (!got && avail[c]) begin
                            got                 = 1'b1;
                            avail[c]            = 1'b0;
                            wr[i]               = 1'b1;
                            ch[i*CH_W +: CH_W]  = CH_W'(c);
                        end
                    end
                    if (!got) drop[i] = 1'b1;
                end
            end
        end
        dir_taken = taken;
    end
endmodule

// File: rtl/loop_buffer_sched.sv
module loop_buffer_sched #(
    parameter int N_PORTS = 4,
    parameter int N_CH    = 8,
    parameter int AGE_W   = 6,
    parameter bit BYPASS  = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [N_PORTS-1:0]                    in_vld,
    input  logic [N_PORTS*$clog2(N_PORTS)-1:0]    in_dst,
    output logic [N_PORTS-1:0]                    in_wr,
    output logic [N_PORTS*$clog2(N_CH)-1:0]       in_ch,
    output logic [N_PORTS-1:0]                    in_dir,
    output logic [N_PORTS-1:0]                    in_drop,
    output logic [2*N_PORTS-1:0]                  out_src,
    output logic [N_PORTS*$clog2(N_CH)-1:0]       out_ch,
    output logic [N_PORTS*$clog2(N_PORTS)-1:0]    out_in,
    output logic [N_CH-1:0]                       ch_rd,
    output logic [$clog2(N_PORTS+1)-1:0]          drop_cnt,
    output logic [N_PORTS*$clog2(N_CH+1)-1:0]     occ_cnt
);
    import lbs_pkg::*;

    localparam int DST_W = $clog2(N_PORTS);
    localparam int CH_W  = $clog2(N_CH);
    localparam int CNT_W = $clog2(N_CH+1);
    localparam int DRP_W = $clog2(N_PORTS+1);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        logic [N_CH-1:0]       occ;
        logic [N_CH-1:0]       cool;
        logic [N_CH*DST_W-1:0] dst;
        logic [N_CH*AGE_W-1:0] age;
    } loop_st_t;

    loop_st_t st_d, st_q;
    logic [N_CH-1:0]    occ_q, cool_q;
    logic [N_CH-1:0]    free_ch;
    logic [N_PORTS-1:0] loop_hit, dir_taken;

    assign occ_q  = st_q.occ;
    assign cool_q = st_q.cool;

    lbs_oldest_pick #(
        .N_OUT(N_PORTS), .N_CH(N_CH), .DST_W(DST_W), .AGE_W(AGE_W)
    ) u_pick (
        .occ(st_q.occ), .dst(st_q.dst), .age(st_q.age),
        .hit(loop_hit), .sel(out_ch), .rd(ch_rd)
    );

    // Channel reuse rule depends on the loop variant
    generate
        if (BYPASS) begin : g_rw_same_slot
            assign free_ch = ~st_q.occ | ch_rd;
        end else begin : g_rw_recovery
            assign free_ch = ~(st_q.occ | ch_rd | st_q.cool);
        end
    endgenerate

    lbs_admit #(
        .N_IO(N_PORTS), .N_CH(N_CH), .DST_W(DST_W), .BYPASS(BYPASS)
    ) u_admit (
        .in_vld(in_vld), .in_dst(in_dst), .free(free_ch), .out_busy(loop_hit),
        .wr(in_wr), .ch(in_ch), .dir(in_dir), .drop(in_drop),
        .dir_taken(dir_taken), .dir_src(out_in)
    );

    generate
        for (genvar j = 0; j < N_PORTS; j++) begin : g_src
            assign out_src[2*j +: 2] = loop_hit[j]  ? SRC_LOOP :
                                       dir_taken[j] ? SRC_DIR  : SRC_IDLE;
        end
    endgenerate

    always_comb begin
        drop_cnt = '0;
        for (int i = 0; i < N_PORTS; i++) drop_cnt = drop_cnt + DRP_W'(in_drop[i]);
    end

    always_comb begin
        occ_cnt = '0;
        for (int j = 0; j < N_PORTS; j++) begin
            logic [CNT_W-1:0] n;
            n = '0;
            for (int c = 0; c < N_CH; c++) begin
                if (st_q.occ[c] && st_q.dst[c*DST_W +: DST_W] == DST_W'(j)) n = n + 1'b1;
            end
            occ_cnt[j*CNT_W +: CNT_W] = n;
        end
    end

    always_comb begin
        logic [CH_W-1:0] w;
        st_d = st_q;
        w    = '0;
        for (int c = 0; c < N_CH; c++) begin
            st_d.cool[c] = !BYPASS && ch_rd[c];
            if (ch_rd[c]) begin
                st_d.occ[c] = 1'b0;
            end else if (st_q.occ[c] && st_q.age[c*AGE_W +: AGE_W] != AGE_MAX) begin
                st_d.age[c*AGE_W +: AGE_W] = st_q.age[c*AGE_W +: AGE_W] + 1'b1;
            end
        end
        for (int i = 0; i < N_PORTS; i++) begin
            if (in_wr[i]) begin
                w                          = in_ch[i*CH_W +: CH_W];
                st_d.occ[w]                = 1'b1;
                st_d.dst[w*DST_W +: DST_W] = in_dst[i*DST_W +: DST_W];
                st_d.age[w*AGE_W +: AGE_W] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/loop_buffer_sched_chk.sv
module loop_buffer_sched_chk #(
    parameter int N_PORTS = 4,
    parameter int N_CH    = 8,
    parameter int AGE_W   = 6,
    parameter bit BYPASS  = 1'b1
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [N_PORTS-1:0]                  in_vld,
    input logic [N_PORTS*$clog2(N_PORTS)-1:0]  in_dst,
    input logic [N_PORTS-1:0]                  in_wr,
    input logic [N_PORTS*$clog2(N_CH)-1:0]     in_ch,
    input logic [N_PORTS-1:0]                  in_dir,
    input logic [N_PORTS-1:0]                  in_drop,
    input logic [2*N_PORTS-1:0]                out_src,
    input logic [N_CH-1:0]                     ch_rd,
    input logic [N_CH-1:0]                     occ_q,
    input logic [N_CH-1:0]                     cool_q
);
    localparam int DST_W = $clog2(N_PORTS);
    localparam int CH_W  = $clog2(N_CH);

    logic [N_CH-1:0] wr_mask;
    int              n_loop;

    always_comb begin
        wr_mask = '0;
        n_loop  = 0;
        for (int i = 0; i < N_PORTS; i++) if (in_wr[i]) wr_mask[in_ch[i*CH_W +: CH_W]] = 1'b1;
        for (int j = 0; j < N_PORTS; j++) if (out_src[2*j +: 2] == 2'b01) n_loop++;
    end

    AST_ONE_READ_PER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ch_rd) == n_loop); // R2

    AST_DROP_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_drop) |-> (&(occ_q | ch_rd | cool_q | wr_mask))); // R6

    generate
        for (genvar i = 0; i < N_PORTS; i++) begin : g_in
            AST_WRITE_FREE_CH: assert property (@(posedge clk) disable iff (!rst_n)
                in_wr[i] |-> (!occ_q[in_ch[i*CH_W +: CH_W]] ||
                              (BYPASS && ch_rd[in_ch[i*CH_W +: CH_W]]))); // R5
            AST_DIR_TO_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
                in_dir[i] |-> (out_src[2*in_dst[i*DST_W +: DST_W] +: 2] == 2'b10)); // R10
            AST_ONE_FATE: assert property (@(posedge clk) disable iff (!rst_n)
                in_vld[i] |-> $onehot({in_wr[i], in_dir[i], in_drop[i]})); // R11
            AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
                !in_vld[i] |-> ({in_wr[i], in_dir[i], in_drop[i]} == 3'b000)); // R11
        end
        if (!BYPASS) begin : g_recov
            for (genvar c = 0; c < N_CH; c++) begin : g_ch
                AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                    ch_rd[c] |=> !wr_mask[c]); // R8
            end
        end
    endgenerate
endmodule

bind loop_buffer_sched loop_buffer_sched_chk #(
    .N_PORTS(N_PORTS), .N_CH(N_CH), .AGE_W(AGE_W), .BYPASS(BYPASS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dst(in_dst),
    .in_wr(in_wr), .in_ch(in_ch), .in_dir(in_dir), .in_drop(in_drop),
    .out_src(out_src), .ch_rd(ch_rd), .occ_q(occ_q), .cool_q(cool_q)
);

// File: tb/test_loop_buffer_sched.sv
`timescale 1ns/1ps
module test_loop_buffer_sched;
    localparam int N    = 4;
    localparam int B    = 8;
    localparam int DW   = $clog2(N);
    localparam int CW   = $clog2(B);
    localparam int CNTW = $clog2(B+1);
    localparam int DRW  = $clog2(N+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    vld = '0;
    logic [N*DW-1:0] dst = '0;
    always #10 clk = ~clk;

    // index 0: bypass variant, index 1: all-buffered variant
    logic [N-1:0]      o_wr [2], o_dir [2], o_drop [2];
    logic [N*CW-1:0]   o_ch [2], o_och [2];
    logic [2*N-1:0]    o_src [2];
    logic [N*DW-1:0]   o_in [2];
    logic [B-1:0]      o_rd [2];
    logic [DRW-1:0]    o_dc [2];
    logic [N*CNTW-1:0] o_occ [2];

    loop_buffer_sched #(.N_PORTS(N), .N_CH(B), .AGE_W(6), .BYPASS(1'b1)) i_loop_buffer_sched (
        .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_dst(dst),
        .in_wr(o_wr[0]), .in_ch(o_ch[0]), .in_dir(o_dir[0]), .in_drop(o_drop[0]),
        .out_src(o_src[0]), .out_ch(o_och[0]), .out_in(o_in[0]), .ch_rd(o_rd[0]),
        .drop_cnt(o_dc[0]), .occ_cnt(o_occ[0]));

    loop_buffer_sched #(.N_PORTS(N), .N_CH(B), .AGE_W(6), .BYPASS(1'b0)) i_loop_buffer_sched_ab (
        .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_dst(dst),
        .in_wr(o_wr[1]), .in_ch(o_ch[1]), .in_dir(o_dir[1]), .in_drop(o_drop[1]),
        .out_src(o_src[1]), .out_ch(o_och[1]), .out_in(o_in[1]), .ch_rd(o_rd[1]),
        .drop_cnt(o_dc[1]), .occ_cnt(o_occ[1]));

    typedef struct {
        logic [N-1:0]      wr, dir, drop;
        logic [N*CW-1:0]   ch, och;
        logic [2*N-1:0]    src;
        logic [N*DW-1:0]   oin;
        logic [B-1:0]      rd;
        int                dc;
        logic [N*CNTW-1:0] occ;
        string             tag;
    } exp_t;

    exp_t q [2][$];
    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    // Reference queue model
    int m_occ [2][B];
    int m_dst [2][B];
    int m_seq [2][B];
    int m_cool [2][B];
    int seqn = 0;

    task automatic model_slot(input int k, output exp_t e);
        bit byp;
        bit rdm [B];
        bit fr [B];
        bit has [N];
        bit taken [N];
        byp = (k == 0);
        e.wr = '0; e.dir = '0; e.drop = '0; e.ch = '0; e.och = '0;
        e.src = '0; e.oin = '0; e.rd = '0; e.dc = 0; e.occ = '0; e.tag = phase;
        for (int c = 0; c < B; c++) rdm[c] = 0;
        for (int j = 0; j < N; j++) begin
            int cnt;
            int best;
            cnt = 0; best = -1; taken[j] = 0;
            for (int c = 0; c < B; c++) begin
                if (m_occ[k][c] != 0 && m_dst[k][c] == j) begin
                    cnt++;
                    if (best < 0 || m_seq[k][c] < m_seq[k][best]) best = c;
                end
            end
            e.occ[j*CNTW +: CNTW] = CNTW'(cnt);
            has[j] = (best >= 0);
            if (best >= 0) begin
                rdm[best] = 1;
                e.rd[best] = 1'b1;
                e.src[2*j +: 2] = 2'b01;
                e.och[j*CW +: CW] = CW'(best);
            end
        end
        for (int c = 0; c < B; c++)
            fr[c] = byp ? (m_occ[k][c] == 0 || rdm[c])
                        : (m_occ[k][c] == 0 && !rdm[c] && m_cool[k][c] == 0);
        for (int i = 0; i < N; i++) begin
            if (vld[i]) begin
                int d;
                int got;
                d = int'(dst[i*DW +: DW]);
                got = -1;
                if (byp && !has[d] && !taken[d]) begin
                    taken[d] = 1;
                    e.dir[i] = 1'b1;
                    e.src[2*d +: 2] = 2'b10;
                    e.oin[d*DW +: DW] = DW'(i);
                end else begin
                    for (int c = 0; c < B; c++) if (got < 0 && fr[c]) got = c;
                    if (got >= 0) begin
                        fr[got] = 0;
                        e.wr[i] = 1'b1;
                        e.ch[i*CW +: CW] = CW'(got);
                    end else begin
                        e.drop[i] = 1'b1;
                        e.dc++;
                    end
                end
            end
        end
        for (int c = 0; c < B; c++) begin
            if (rdm[c]) m_occ[k][c] = 0;
            m_cool[k][c] = (!byp && rdm[c]) ? 1 : 0;
        end
        for (int i = 0; i < N; i++) begin
            if (e.wr[i]) begin
                int c;
                c = int'(e.ch[i*CW +: CW]);
                m_occ[k][c] = 1;
                m_dst[k][c] = int'(dst[i*DW +: DW]);
                m_seq[k][c] = seqn++;
            end
        end
    endtask

    task automatic chk(input string req, input string what, input int k,
                       input logic [63:0] act, input logic [63:0] exp_v, input string tag);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s [%s] dut%0d %s: actual=%h expected=%h", req, tag, k, what, act, exp_v);
        end
    endtask

    // Driver: apply one slot of inputs and push the expected decisions
    task automatic slot(input logic [N-1:0] v, input logic [N*DW-1:0] d);
        exp_t e;
        @(negedge clk);
        vld = v;
        dst = d;
        for (int k = 0; k < 2; k++) begin
            model_slot(k, e);
            q[k].push_back(e);
        end
    endtask

    function automatic logic [N*DW-1:0] same_dst(input int p);
        logic [N*DW-1:0] r;
        for (int i = 0; i < N; i++) r[i*DW +: DW] = DW'(p);
        return r;
    endfunction

    // Monitor: compare in the low phase of the clock
    always @(negedge clk) begin
        #5;
        for (int k = 0; k < 2; k++) begin
            if (q[k].size() > 0) begin
                exp_t e;
                e = q[k].pop_front();
                chk("R2",  "ch_rd",    k, 64'(o_rd[k]),   64'(e.rd),  e.tag);
                chk("R2",  "out_ch",   k, 64'(o_och[k]),  64'(e.och), e.tag);
                chk(k == 0 ? "R3" : "R4", "out_src", k, 64'(o_src[k]), 64'(e.src), e.tag);
                chk(k == 0 ? "R3" : "R4", "in_dir",  k, 64'(o_dir[k]), 64'(e.dir), e.tag);
                chk("R3",  "out_in",   k, 64'(o_in[k]),   64'(e.oin), e.tag);
                chk("R5",  "in_wr",    k, 64'(o_wr[k]),   64'(e.wr),  e.tag);
                chk(k == 0 ? "R7" : "R8", "in_ch", k, 64'(o_ch[k]), 64'(e.ch), e.tag);
                chk("R6",  "in_drop",  k, 64'(o_drop[k]), 64'(e.drop), e.tag);
                chk("R6",  "drop_cnt", k, 64'(o_dc[k]),   64'(e.dc),  e.tag);
                chk("R9",  "occ_cnt",  k, 64'(o_occ[k]),  64'(e.occ), e.tag);
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < B; c++) begin
                m_occ[k][c] = 0; m_dst[k][c] = 0; m_seq[k][c] = 0; m_cool[k][c] = 0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty loop right after reset
        phase = "R1";
        slot('0, '0);

        // R3/R4: three inputs to port 1 and one to port 2
        phase = "R3_R4";
        slot(4'b1111, {2'd2, 2'd1, 2'd1, 2'd1});
        // R10/R2: port 1 now has loop packets, a new arrival must go to the loop
        phase = "R10_R2";
        slot(4'b0001, {2'd0, 2'd0, 2'd0, 2'd1});
        // R11: invalid inputs with garbage destinations
        phase = "R11";
        slot(4'b0000, {2'd3, 2'd2, 2'd1, 2'd0});
        slot(4'b0000, {2'd1, 2'd1, 2'd1, 2'd1});

        // R6/R7/R8: hot spot on port 0 fills the loop, forcing drops and channel reuse
        phase = "R6_R7_R8";
        for (int s = 0; s < 6; s++) slot(4'b1111, same_dst(0));
        phase = "R8_drain";
        for (int s = 0; s < 10; s++) slot(4'b0000, '0);

        // R2: equal-age packets for one port leave in channel order
        phase = "R2_ties";
        slot(4'b1111, same_dst(3));
        slot(4'b1111, same_dst(3));
        for (int s = 0; s < 10; s++) slot(4'b0000, '0);

        // Mixed traffic with periodic idle stretches
        phase = "R5_R9_mixed";
        for (int blk = 0; blk < 12; blk++) begin
            for (int s = 0; s < 30; s++) begin
                logic [N*DW-1:0] d;
                logic [N-1:0] v;
                v = N'($urandom);
                for (int i = 0; i < N; i++)
                    d[i*DW +: DW] = (blk % 3 == 0) ? DW'($urandom % 2) : DW'($urandom % N);
                slot(v, d);
            end
            for (int s = 0; s < 9; s++) slot(4'b0000, '0);
        end

        @(negedge clk);
        vld = '0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule